// File: doc/BRIEF.md
# BF16 Pairwise Dot-Product Accumulator

This block updates a vector of single-precision accumulators, one per 32-bit lane. In every active lane it takes two 16-bit brain-float values from a source-1 word and two from a source-2 word, forms two products, and adds them to the lane's accumulator one after the other. The upper-half product goes in first. The lower-half product is then added to that rounded intermediate. When broadcast is selected, the lowest source-2 word feeds every lane.

Arithmetic follows one fixed policy and cannot be configured. Additions round to nearest-even. Subnormal inputs count as zero, subnormal results are flushed to zero, and no flags are raised. A per-lane mask chooses between the computed value and either the old accumulator (merge) or zero (zeroing). Results are registered with a one-cycle latency and come with a valid strobe.

Top module: `bf16_dot_acc`

## Requirements
- R1: Lane i uses bits [32i+31:32i+16] and [32i+15:32i] of `src1` paired with the same halves of its source-2 word. That word is `src2` lane i, or `src2[31:0]` when `bcast` is 1.
- R2: The result is round(round(acc + hi_product) + lo_product). Each addition rounds to nearest, ties to even. A BF16 value widens to FP32 by appending 16 zero bits.
- R3: A NaN input, infinity times zero, or infinities of opposite sign meeting in an addition give 32'h7FC00000.
- R4: An accumulator or BF16 operand with exponent field 0 is treated as a zero of the same sign.
- R5: A product or sum whose magnitude lies below 2^-126 becomes a zero carrying the sign of that value.
- R6: A product or sum beyond the largest finite FP32 value becomes infinity of its sign (exponent 8'hFF, fraction 0).
- R7: An exact zero sum is +0 unless both addends are -0, which gives -0.
- R8: A lane whose `lane_mask` bit is 0 outputs its `acc_in` word unchanged when `zero_masked` is 0, and 32'h0 when `zero_masked` is 1.
- R9: `out_valid` equals `in_valid` one cycle later. `out_acc` changes only in the cycle after `in_valid` is 1.
- R10: During reset, `out_valid` is 0 and `out_acc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| acc_in | input | 32*LANES | Accumulator words, one per lane |
| src1 | input | 32*LANES | Two BF16 values per lane |
| src2 | input | 32*LANES | Two BF16 values per lane |
| bcast | input | 1 | Use src2 lane 0 for every lane |
| lane_mask | input | LANES | 1 = lane computes |
| zero_masked | input | 1 | Masked lanes output zero instead of the old accumulator |
| out_valid | output | 1 | out_acc updated this cycle |
| out_acc | output | 32*LANES | Updated accumulator words |

## Verification
The ordering and double rounding of the two additions are hard to observe. For most operands, adding the two products in either order, or fusing them, gives the same bits. The stimulus therefore includes operand sets where the order matters. In one, a 2^24 upper product swallows a unit accumulator and a -2^24 lower product then cancels it. In another, an exact tie at 2^24 must round to even. Random operands are confined to an exponent window in which the bench's double-precision sums are exact. Directed vectors cover flushing to zero, overflow, the invalid cases and the sign of zero.

// File: rtl/bf16_dot_acc.sv
module bf16_dot_acc #(
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [32*LANES-1:0] acc_in,
  input  logic [32*LANES-1:0] src1,
  input  logic [32*LANES-1:0] src2,
  input  logic                bcast,
  input  logic [LANES-1:0]    lane_mask,
  input  logic                zero_masked,
  output logic                out_valid,
  output logic [32*LANES-1:0] out_acc
);
  localparam int W = 32 * LANES;
  localparam logic [31:0] QNAN = 32'h7FC00000;

  function automatic logic [31:0] fmul(input logic [15:0] a, input logic [15:0] b);
    logic s, ia, ib, za, zb, na, nb;
    logic [15:0] p;
    logic [22:0] fr;
    int e;
    s  = a[15] ^ b[15];
    na = (a[14:7] == 8'hFF) && (a[6:0] != 0);
    nb = (b[14:7] == 8'hFF) && (b[6:0] != 0);
    ia = (a[14:7] == 8'hFF) && !na;
    ib = (b[14:7] == 8'hFF) && !nb;
    za = a[14:7] == 8'h00;
    zb = b[14:7] == 8'h00;
    p  = 16'({1'b1, a[6:0]}) * 16'({1'b1, b[6:0]});
    e  = int'(a[14:7]) + int'(b[14:7]) - 127;
    if (p[15]) begin
      e  = e + 1;
      fr = {p[14:0], 8'b0};
    end else begin
      fr = {p[13:0], 9'b0};
    end
    if (na || nb || (ia && zb) || (za && ib)) return QNAN;
    if (ia || ib) return {s, 8'hFF, 23'b0};
    if (za || zb || e <= 0) return {s, 31'b0};
    if (e >= 255) return {s, 8'hFF, 23'b0};
    return {s, e[7:0], fr};
  endfunction

  function automatic logic [31:0] fadd(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] a, b;
    logic [26:0] ma, mb, mbs, m;
    logic [27:0] sum;
    logic [24:0] mr;
    logic [7:0] d;
    logic up, found;
    int e, lz;
    if ((x[30:23] == 8'hFF && x[22:0] != 0) || (y[30:23] == 8'hFF && y[22:0] != 0)) return QNAN;
    if (x[30:23] == 8'hFF && y[30:23] == 8'hFF) return (x[31] != y[31]) ? QNAN : x;
    if (x[30:23] == 8'hFF) return x;
    if (y[30:23] == 8'hFF) return y;
    if (x[30:23] == 0 && y[30:23] == 0) return {x[31] & y[31], 31'b0};
    if (x[30:23] == 0) return y;
    if (y[30:23] == 0) return x;
    if (y[30:0] > x[30:0]) begin a = y; b = x; end
    else begin a = x; b = y; end
    ma = {1'b1, a[22:0], 3'b0};
    mb = {1'b1, b[22:0], 3'b0};
    d  = a[30:23] - b[30:23];
    if (d >= 8'd27) mbs = 27'd1;
    else mbs = (mb >> d) | 27'(|(mb & ((27'd1 << d) - 27'd1)));
    e = int'(a[30:23]);
    if (a[31] == b[31]) begin
      sum = {1'b0, ma} + {1'b0, mbs};
      if (sum[27]) begin
        m = {sum[27:2], sum[1] | sum[0]};
        e = e + 1;
      end else begin
        m = sum[26:0];
      end
    end else begin
      m = ma - mbs;
      if (m == 0) return 32'h0;
      lz = 0;
      found = 1'b0;
      for (int k = 26; k >= 0; k--)
        if (!found && m[k]) begin lz = 26 - k; found = 1'b1; end
      m = m << lz;
      e = e - lz;
    end
    if (e <= 0) return {a[31], 31'b0};
    up = m[2] & (m[1] | m[0] | m[3]);
    mr = {1'b0, m[26:3]} + 25'(up);
    if (mr[24]) e = e + 1;
    if (e >= 255) return {a[31], 8'hFF, 23'b0};
    return {a[31], e[7:0], mr[24] ? 23'b0 : mr[22:0]};
  endfunction

  logic [W-1:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [31:0] s1, s2, acc, hi_p, lo_p, mid, res;
    assign acc  = acc_in[32*i +: 32];
    assign s1   = src1[32*i +: 32];
    assign s2   = bcast ? src2[31:0] : src2[32*i +: 32];
    assign hi_p = fmul(s1[31:16], s2[31:16]);
    assign lo_p = fmul(s1[15:0], s2[15:0]);
    assign mid  = fadd(acc, hi_p);
    assign res  = fadd(mid, lo_p);
    assign nxt[32*i +: 32] = lane_mask[i] ? res : (zero_masked ? 32'h0 : acc);

    a_r8_zeroing: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !lane_mask[i] && zero_masked |=> out_acc[32*i +: 32] == 32'h0);
    a_r8_merge: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !lane_mask[i] && !zero_masked |=> out_acc[32*i +: 32] == $past(acc_in[32*i +: 32]));
    a_r3_nan_acc: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && lane_mask[i] && acc[30:23] == 8'hFF && acc[22:0] != 0 |=> out_acc[32*i +: 32] == QNAN);
    a_r5_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && lane_mask[i] |=> out_acc[32*i+23 +: 8] != 8'h00 || out_acc[32*i +: 23] == 23'h0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_acc <= nxt;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_acc));
endmodule

// File: tb/bf16_dot_acc_tb.sv
module bf16_dot_acc_tb;
  localparam int PERIOD = 10;
  localparam int LANES = 4;
  localparam int W = 32 * LANES;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, bcast = 1'b0, zero_masked = 1'b0;
  logic [W-1:0] acc_in = '0, src1 = '0, src2 = '0;
  logic [LANES-1:0] lane_mask = '0;
  logic out_valid;
  logic [W-1:0] out_acc;

  int checks = 0, errors = 0;
  logic exp_v = 1'b0;
  logic [W-1:0] exp_res = '0;
  string prev_tag = "R10";
  bit done = 0;

  bf16_dot_acc #(.LANES(LANES)) u_dut (.clk, .rst_n, .in_valid, .acc_in, .src1, .src2,
    .bcast, .lane_mask, .zero_masked, .out_valid, .out_acc);

  always #(PERIOD/2) clk = ~clk;

  function automatic real f2r(input logic [31:0] f);
    logic [10:0] de;
    if (f[30:23] == 0) return $bitstoreal({f[31], 63'b0});
    de = 11'(int'(f[30:23]) + 896);
    return $bitstoreal({f[31], de, f[22:0], 29'b0});
  endfunction

  function automatic logic [31:0] r2f(input real x);
    logic [63:0] b;
    logic [24:0] m;
    logic up;
    int fe;
    b = $realtobits(x);
    if (b[62:52] == 0) return {b[63], 31'b0};
    fe = int'(b[62:52]) - 896;
    up = (b[28:0] > 29'h10000000) || (b[28:0] == 29'h10000000 && b[29]);
    m = {2'b01, b[51:29]} + 25'(up);
    if (m[24]) fe++;
    if (fe <= 0) return {b[63], 31'b0};
    if (fe >= 255) return {b[63], 8'hFF, 23'b0};
    return {b[63], fe[7:0], m[24] ? 23'b0 : m[22:0]};
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] a, s1, s2, input logic bc,
                                         input logic [LANES-1:0] m, input logic z);
    logic [W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] w1, w2, t;
      w1 = s1[32*i +: 32];
      w2 = bc ? s2[31:0] : s2[32*i +: 32];
      if (!m[i]) r[32*i +: 32] = z ? 32'h0 : a[32*i +: 32];
      else begin
        t = r2f(f2r(a[32*i +: 32]) + f2r({w1[31:16], 16'b0}) * f2r({w2[31:16], 16'b0}));
        r[32*i +: 32] = r2f(f2r(t) + f2r({w1[15:0], 16'b0}) * f2r({w2[15:0], 16'b0}));
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] rbf();
    logic [7:0] e;
    e = 8'(122 + $urandom % 11);
    return {1'($urandom), e, 7'($urandom)};
  endfunction

  function automatic logic [31:0] racc();
    logic [7:0] e;
    e = 8'(117 + $urandom % 21);
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid !== exp_v || out_acc !== exp_res) begin
      errors++;
      $display("FAIL %s: valid=%0b acc=%h expected valid=%0b acc=%h", prev_tag, out_valid, out_acc, exp_v, exp_res);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] a, s1v, s2v, input logic bc,
                      input logic [LANES-1:0] m, input logic z, input logic [W-1:0] e, input string tag);
    @(negedge clk);
    check_out();
    in_valid = v; acc_in = a; src1 = s1v; src2 = s2v; bcast = bc; lane_mask = m; zero_masked = z;
    exp_v = v;
    if (v) exp_res = e;
    prev_tag = tag;
  endtask

  task automatic dir(input logic [31:0] a, s1v, s2v, e, input string tag);
    step(1'b1, {LANES{a}}, {LANES{s1v}}, {LANES{s2v}}, 1'b0, '1, 1'b0, {LANES{e}}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_acc !== '0) begin
      errors++;
      $display("FAIL R10: valid=%0b acc=%h expected 0 and 0", out_valid, out_acc);
    end
    rst_n = 1'b1;
    dir(32'h3F800000, 32'h7FC03F80, 32'h3F803F80, 32'h7FC00000, "R3 nan operand");
    dir(32'h7F800001, 32'h3F803F80, 32'h3F803F80, 32'h7FC00000, "R3 nan acc");
    dir(32'h3F800000, 32'h7F800000, 32'h00003F80, 32'h7FC00000, "R3 inf*0");
    dir(32'h7F800000, 32'hFF800000, 32'h3F803F80, 32'h7FC00000, "R3 inf-inf");
    dir(32'h80000000, 32'h80008000, 32'h3F803F80, 32'h80000000, "R7 neg zeros");
    dir(32'h3F800000, 32'hBF800000, 32'h3F803F80, 32'h00000000, "R7 cancel");
    dir(32'h3F800000, 32'h4B80CB80, 32'h3F803F80, 32'h00000000, "R2 order");
    dir(32'h4B800001, 32'h3F800000, 32'h3F803F80, 32'h4B800002, "R2 tie even");
    dir(32'h00000001, 32'h00000000, 32'h3F803F80, 32'h00000000, "R4 acc subnormal");
    dir(32'h40000000, 32'h00013F80, 32'h3F803F80, 32'h40400000, "R4 bf16 subnormal");
    dir(32'h00800000, 32'h80C08000, 32'h3F803F80, 32'h80000000, "R5 sum flush");
    dir(32'h3F800000, 32'h00800000, 32'h00803F80, 32'h3F800000, "R5 product flush");
    dir(32'h7F7FFFFF, 32'h7F000000, 32'h3F803F80, 32'h7F800000, "R6 sum overflow");
    dir(32'h00000000, 32'hFF000000, 32'h7F003F80, 32'hFF800000, "R6 product overflow");
    step(1'b1, {32'h00000001, 32'h3F800000, 32'h00000001, 32'h3F800000}, {LANES{32'h3F803F80}},
         {LANES{32'h3F803F80}}, 1'b0, 4'b0101, 1'b0,
         {32'h00000001, 32'h40400000, 32'h00000001, 32'h40400000}, "R8 merge");
    step(1'b1, {32'h00000001, 32'h3F800000, 32'h00000001, 32'h3F800000}, {LANES{32'h3F803F80}},
         {LANES{32'h3F803F80}}, 1'b0, 4'b0101, 1'b1,
         {32'h00000000, 32'h40400000, 32'h00000000, 32'h40400000}, "R8 zeroing");
    step(1'b0, '1, '1, '1, 1'b0, '1, 1'b0, '0, "R9 hold");
    step(1'b0, '0, '0, '0, 1'b0, '1, 1'b1, '0, "R9 hold");
    step(1'b1, {LANES{32'h3F800000}}, {32'h40004000, 32'h3F803F80, 32'h40403F80, 32'h3F804000},
         {32'h0, 32'h0, 32'h0, 32'h40003F80}, 1'b1, '1, 1'b0, '0, "R1 broadcast");
    exp_res = model({LANES{32'h3F800000}}, {32'h40004000, 32'h3F803F80, 32'h40403F80, 32'h3F804000},
                    {32'h0, 32'h0, 32'h0, 32'h40003F80}, 1'b1, '1, 1'b0);
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] a, s1v, s2v;
      logic bc, z, v;
      logic [LANES-1:0] m;
      for (int i = 0; i < LANES; i++) begin
        a[32*i +: 32] = racc();
        s1v[32*i +: 32] = {rbf(), rbf()};
        s2v[32*i +: 32] = {rbf(), rbf()};
      end
      bc = 1'($urandom % 4 == 0);
      z = 1'($urandom);
      m = ($urandom % 3 == 0) ? LANES'($urandom) : '1;
      v = 1'($urandom % 5 != 0);
      step(v, a, s1v, s2v, bc, m, z, model(a, s1v, s2v, bc, m, z), "R1 R2 random");
    end
    step(1'b0, '0, '0, '0, 1'b0, '0, 1'b0, '0, "R9 idle");
    @(negedge clk);
    check_out();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule